// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Bank

This block watches up to 32 asynchronous external lines and turns selected signal transitions into latched interrupt requests. Each line first passes through a two-flop synchronizer. An edge is then found by comparing the newest synchronized sample with the one before it. Two per-line select registers choose whether a rising transition, a falling transition, both or neither is captured. Captured rising and falling transitions are kept in two separate flag registers. Software clears a flag by writing one to its bit.

One level output, `bank_irq`, summarises the bank. It is high while any flagged line also has its interrupt enable bit set. A second, independent path sends a single-cycle pulse per line whenever an edge is captured on a line whose event enable bit is set. Software can raise a line's rising flag without any pin activity by writing its soft-trigger bit. The parameter `IMPL_MASK` says which lines physically exist. Register bits of absent lines are stuck at zero, so software finds the populated lines by writing all ones to the rising select register and reading it back.

Registers are reached through a plain single-cycle port. A write happens on the clock edge while `reg_wr` is high. Reads are combinational from `reg_addr`.

Top module: `xint_bank`

## Requirements
- R1: After reset every register reads 0, `bank_irq` is 0 and `line_event` is 0.
- R2: A line whose bit is set in the rising select register (offset 0x00) sets its bit in the rising flag register (offset 0x0C) on a 0-to-1 pin transition. The flag is visible after the third rising clock edge that follows the pin change. A rising transition on a line whose rising select bit is 0 flags nothing.
- R3: A line whose bit is set in the falling select register (offset 0x04) sets its bit in the falling flag register (offset 0x10) on a 1-to-0 transition. A line with both select bits set records each direction in its own flag register.
- R4: Writing 1 to a bit of either flag register clears only that bit. Writing 0 leaves the register unchanged. No flag bit ever falls without such a write.
- R5: `bank_irq` is 1 exactly while some line has a rising or falling flag set and its bit in the interrupt enable register (offset 0x80) is 1. A flag on a line whose enable bit is 0 does not raise it. `bank_irq` stays high until every enabled flag is cleared.
- R6: `line_event` bit n pulses for one cycle, in the same cycle the flag is set, when an edge is captured on line n and bit n of the event enable register (offset 0x84) is 1. The pulse does not depend on the interrupt enable register or on the flag state.
- R7: Writing 1 to a bit of the soft-trigger register (offset 0x08) whose interrupt enable bit is 1 sets that line's rising flag after the same clock edge. The soft-trigger bit then reads 1 until that rising flag bit is cleared, and then it reads 0. A soft-trigger write to a line whose enable bit is 0 has no effect.
- R8: Bits of lines absent from `IMPL_MASK` read 0 in every register and never flag. Writing all ones to offset 0x00 reads back exactly `IMPL_MASK`.
- R9: If a captured edge and a clearing write hit the same flag bit in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe; the write takes effect on the rising clock edge |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data, one bit per line |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| ext_lines | input | 32 | Asynchronous external interrupt pins |
| bank_irq | output | 1 | Combined level interrupt for the bank |
| line_event | output | 32 | Per-line single-cycle event pulses |

## Verification
A pin change made at a falling clock edge reaches a flag, `bank_irq` and `line_event` after three rising edges: two synchronizer stages and then the capture register. The bench therefore waits three falling edges after driving a pin before it samples. The event pulse is also sampled one cycle before and one cycle after that window to confirm that it lasts a single cycle. A register write applies on the next rising edge, and a soft trigger sets its flag on that same edge, so readback and the interrupt level are checked at the following falling edge. Reads are combinational, so they are sampled a moment after the address settles, away from any clock edge. The edge-versus-clear collision is set up by placing the clearing write on the exact edge where the synchronized transition is captured.

// File: rtl/xint_pkg.sv
package xint_pkg;

    localparam int LINES = 32;
    localparam int AW    = 8;

    typedef logic [LINES-1:0] line_vec_t;

    // Register byte offsets (software-visible, fixed)
    localparam logic [AW-1:0] OFS_RISE_SEL  = 8'h00;
    localparam logic [AW-1:0] OFS_FALL_SEL  = 8'h04;
    localparam logic [AW-1:0] OFS_SOFT      = 8'h08;
    localparam logic [AW-1:0] OFS_RISE_FLAG = 8'h0C;
    localparam logic [AW-1:0] OFS_FALL_FLAG = 8'h10;
    localparam logic [AW-1:0] OFS_IRQ_EN    = 8'h80;
    localparam logic [AW-1:0] OFS_EVT_EN    = 8'h84;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RISE_SEL,
        SEL_FALL_SEL,
        SEL_SOFT,
        SEL_RISE_FLAG,
        SEL_FALL_FLAG,
        SEL_IRQ_EN,
        SEL_EVT_EN
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [AW-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_RISE_SEL:  s = SEL_RISE_SEL;
            OFS_FALL_SEL:  s = SEL_FALL_SEL;
            OFS_SOFT:      s = SEL_SOFT;
            OFS_RISE_FLAG: s = SEL_RISE_FLAG;
            OFS_FALL_FLAG: s = SEL_FALL_FLAG;
            OFS_IRQ_EN:    s = SEL_IRQ_EN;
            OFS_EVT_EN:    s = SEL_EVT_EN;
            default:       s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/xint_edge.sv
module xint_edge
    import xint_pkg::*;
#(
    parameter line_vec_t IMPL = '1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  line_vec_t pins,
    output line_vec_t rise_det,
    output line_vec_t fall_det
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        if (IMPL[i]) begin : g_impl
            logic [1:0] meta;
            logic       prev;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta <= '0;
                    prev <= 1'b0;
                end else begin
                    meta <= {meta[0], pins[i]};
                    prev <= meta[1];
                end
            end

            assign rise_det[i] =  meta[1] & ~prev;
            assign fall_det[i] = ~meta[1] &  prev;
        end else begin : g_absent
            logic unused_pin;
            assign unused_pin  = pins[i];
            assign rise_det[i] = 1'b0;
            assign fall_det[i] = 1'b0;
        end
    end

endmodule

// File: rtl/xint_cfg.sv
module xint_cfg
    import xint_pkg::*;
#(
    parameter line_vec_t IMPL = '1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr,
    input  reg_sel_e  sel,
    input  line_vec_t wdata,
    output line_vec_t rise_sel,
    output line_vec_t fall_sel,
    output line_vec_t irq_en,
    output line_vec_t evt_en
);

    line_vec_t wmask;
    assign wmask = wdata & IMPL;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_sel <= '0;
            fall_sel <= '0;
            irq_en   <= '0;
            evt_en   <= '0;
        end else if (wr) begin
            case (sel)
                SEL_RISE_SEL: rise_sel <= wmask;
                SEL_FALL_SEL: fall_sel <= wmask;
                SEL_IRQ_EN:   irq_en   <= wmask;
                SEL_EVT_EN:   evt_en   <= wmask;
                default:      ;
            endcase
        end
    end

endmodule

// File: rtl/xint_flags.sv
module xint_flags
    import xint_pkg::*;
#(
    parameter line_vec_t IMPL = '1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  line_vec_t rise_set,
    input  line_vec_t fall_set,
    input  line_vec_t soft_set,
    input  line_vec_t rise_clr,
    input  line_vec_t fall_clr,
    output line_vec_t rise_q,
    output line_vec_t fall_q,
    output line_vec_t soft_q
);

    // Set terms are ORed in after the clear, so a same-cycle edge wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q <= '0;
            fall_q <= '0;
            soft_q <= '0;
        end else begin
            rise_q <= ((rise_q & ~rise_clr) | rise_set | soft_set) & IMPL;
            fall_q <= ((fall_q & ~fall_clr) | fall_set) & IMPL;
            soft_q <= ((soft_q & ~rise_clr) | soft_set) & IMPL;
        end
    end

    // R4
    rise_fall_only_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(rise_q) & ~rise_q) & ~$past(rise_clr)) == '0));

    // R4
    fall_fall_only_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(fall_q) & ~fall_q) & ~$past(fall_clr)) == '0));

    // R9
    edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rise_set & rise_clr)) |=>
        ((rise_q & $past(rise_set & rise_clr)) == $past(rise_set & rise_clr)));

    // R7
    soft_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((soft_q & ~rise_q) == '0));

endmodule

// File: rtl/xint_bank.sv
module xint_bank
    import xint_pkg::*;
#(
    parameter logic [31:0] IMPL_MASK = 32'h00FF_FFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [31:0] ext_lines,
    output logic        bank_irq,
    output logic [31:0] line_event
);

    reg_sel_e  sel;
    line_vec_t rise_det, fall_det, rise_cap, fall_cap;
    line_vec_t rise_sel, fall_sel, irq_en, evt_en;
    line_vec_t rise_flag, fall_flag, soft_bits;
    line_vec_t rise_clr, fall_clr, soft_set;
    line_vec_t evt_q;

    assign sel = decode_addr(reg_addr);

    xint_edge #(.IMPL(IMPL_MASK)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins     (ext_lines),
        .rise_det (rise_det),
        .fall_det (fall_det)
    );

    xint_cfg #(.IMPL(IMPL_MASK)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .sel      (sel),
        .wdata    (reg_wdata),
        .rise_sel (rise_sel),
        .fall_sel (fall_sel),
        .irq_en   (irq_en),
        .evt_en   (evt_en)
    );

    assign rise_cap = rise_det & rise_sel;
    assign fall_cap = fall_det & fall_sel;

    assign rise_clr = (reg_wr && sel == SEL_RISE_FLAG) ? (reg_wdata & IMPL_MASK) : '0;
    assign fall_clr = (reg_wr && sel == SEL_FALL_FLAG) ? (reg_wdata & IMPL_MASK) : '0;
    assign soft_set = (reg_wr && sel == SEL_SOFT)      ? (reg_wdata & irq_en)    : '0;

    xint_flags #(.IMPL(IMPL_MASK)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_set (rise_cap),
        .fall_set (fall_cap),
        .soft_set (soft_set),
        .rise_clr (rise_clr),
        .fall_clr (fall_clr),
        .rise_q   (rise_flag),
        .fall_q   (fall_flag),
        .soft_q   (soft_bits)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= (rise_cap | fall_cap) & evt_en;
    end

    assign line_event = evt_q;
    assign bank_irq   = |((rise_flag | fall_flag) & irq_en);

    always_comb begin
        unique case (sel)
            SEL_RISE_SEL:  reg_rdata = rise_sel;
            SEL_FALL_SEL:  reg_rdata = fall_sel;
            SEL_SOFT:      reg_rdata = soft_bits;
            SEL_RISE_FLAG: reg_rdata = rise_flag;
            SEL_FALL_FLAG: reg_rdata = fall_flag;
            SEL_IRQ_EN:    reg_rdata = irq_en;
            SEL_EVT_EN:    reg_rdata = evt_en;
            SEL_NONE:      reg_rdata = '0;
        endcase
    end

    // R6
    event_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((line_event & ~$past(evt_en)) == '0));

    // R8
    absent_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_rdata & ~IMPL_MASK) == '0));

    // R5
    irq_drop_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bank_irq) |-> $past(reg_wr));

endmodule

// File: tb/xint_bank_bench.sv
`timescale 1ns/1ps
module xint_bank_bench;

    localparam logic [31:0] IMPL = 32'h00FF_FFFF;
    localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_D = 2'd2, OP_I = 2'd3;
    localparam int NV = 39;

    // {op, addr, data, expected, requirement}
    localparam logic [77:0] VT [NV] = '{
        {OP_R, 8'h00, 32'h0, 32'h0, 4'd1},              // R1 reset readback
        {OP_R, 8'h80, 32'h0, 32'h0, 4'd1},              // R1
        {OP_R, 8'h0C, 32'h0, 32'h0, 4'd1},              // R1
        {OP_I, 8'h00, 32'h0, 32'h0, 4'd1},              // R1 irq low
        {OP_W, 8'h00, 32'hFFFF_FFFF, 32'h0, 4'd8},      // R8 discover lines
        {OP_R, 8'h00, 32'h0, 32'h00FF_FFFF, 4'd8},      // R8
        {OP_W, 8'h00, 32'h0000_0005, 32'h0, 4'd2},      // R2 rise on 0,2
        {OP_W, 8'h04, 32'h0000_0006, 32'h0, 4'd3},      // R3 fall on 1,2
        {OP_W, 8'h80, 32'h0000_0001, 32'h0, 4'd5},      // R5 enable line 0
        {OP_D, 8'h00, 32'h4000_0007, 32'h0, 4'd2},      // R2 rise 0,1,2,30
        {OP_R, 8'h0C, 32'h0, 32'h0000_0005, 4'd2},      // R2
        {OP_R, 8'h10, 32'h0, 32'h0, 4'd3},              // R3 no fall yet
        {OP_I, 8'h00, 32'h0, 32'h1, 4'd5},              // R5
        {OP_D, 8'h00, 32'h0000_0000, 32'h0, 4'd3},      // R3 all fall
        {OP_R, 8'h10, 32'h0, 32'h0000_0006, 4'd3},      // R3
        {OP_R, 8'h0C, 32'h0, 32'h0000_0005, 4'd3},      // R3 rise kept
        {OP_W, 8'h0C, 32'h0000_0001, 32'h0, 4'd4},      // R4 clear bit0
        {OP_R, 8'h0C, 32'h0, 32'h0000_0004, 4'd4},      // R4
        {OP_W, 8'h0C, 32'h0000_0000, 32'h0, 4'd4},      // R4 write zero
        {OP_R, 8'h0C, 32'h0, 32'h0000_0004, 4'd4},      // R4
        {OP_I, 8'h00, 32'h0, 32'h0, 4'd5},              // R5 masked flags
        {OP_W, 8'h80, 32'h0000_0004, 32'h0, 4'd5},      // R5
        {OP_I, 8'h00, 32'h0, 32'h1, 4'd5},              // R5
        {OP_W, 8'h0C, 32'h0000_0004, 32'h0, 4'd5},      // R5
        {OP_I, 8'h00, 32'h0, 32'h1, 4'd5},              // R5 fall flag holds
        {OP_W, 8'h10, 32'h0000_0006, 32'h0, 4'd5},      // R5
        {OP_I, 8'h00, 32'h0, 32'h0, 4'd5},              // R5
        {OP_R, 8'h10, 32'h0, 32'h0, 4'd4},              // R4
        {OP_W, 8'h80, 32'hFFFF_FFFF, 32'h0, 4'd8},      // R8
        {OP_R, 8'h80, 32'h0, 32'h00FF_FFFF, 4'd8},      // R8
        {OP_W, 8'h80, 32'h0000_0100, 32'h0, 4'd7},      // R7
        {OP_W, 8'h08, 32'h0000_0300, 32'h0, 4'd7},      // R7 line 9 disabled
        {OP_R, 8'h08, 32'h0, 32'h0000_0100, 4'd7},      // R7
        {OP_R, 8'h0C, 32'h0, 32'h0000_0100, 4'd7},      // R7
        {OP_I, 8'h00, 32'h0, 32'h1, 4'd7},              // R7
        {OP_W, 8'h0C, 32'h0000_0100, 32'h0, 4'd7},      // R7
        {OP_R, 8'h08, 32'h0, 32'h0, 4'd7},              // R7 self-clear
        {OP_R, 8'h0C, 32'h0, 32'h0, 4'd7},              // R7
        {OP_I, 8'h00, 32'h0, 32'h0, 4'd7}               // R7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] ext_lines = '0;
    logic        bank_irq;
    logic [31:0] line_event;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xint_bank #(.IMPL_MASK(IMPL)) u_xint_bank (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_lines(ext_lines),
        .bank_irq(bank_irq), .line_event(line_event)
    );

    task automatic chk(input int req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL R%0d: got %h expected %h", req, got, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input int req, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic drive(input logic [31:0] v);
        ext_lines = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(1, line_event, 32'h0);   // R1

        for (int k = 0; k < NV; k++) begin
            logic [1:0]  op;
            logic [7:0]  a;
            logic [31:0] d, e;
            logic [3:0]  rq;
            {op, a, d, e, rq} = VT[k];
            case (op)
                OP_W: wr_reg(a, d);
                OP_R: begin rd_chk(int'(rq), a, e); @(negedge clk); end
                OP_D: drive(d);
                default: begin #1; chk(int'(rq), {31'h0, bank_irq}, e); @(negedge clk); end
            endcase
        end

        // R6: event pulse, one cycle, independent of interrupt enable
        wr_reg(8'h84, 32'h0000_0001);
        wr_reg(8'h80, 32'h0000_0000);
        ext_lines = 32'h0000_0005;
        @(negedge clk); chk(6, line_event, 32'h0);
        @(negedge clk); chk(6, line_event, 32'h0);
        @(negedge clk); chk(6, line_event, 32'h0000_0001);
        #1; chk(5, {31'h0, bank_irq}, 32'h0);           // R5 enable off
        @(negedge clk); chk(6, line_event, 32'h0);
        rd_chk(2, 8'h0C, 32'h0000_0005);

        // R9: clear collides with a new capture on line 0
        wr_reg(8'h0C, 32'h0000_0005);
        drive(32'h0000_0000);
        rd_chk(4, 8'h0C, 32'h0);
        ext_lines = 32'h0000_0001;
        @(negedge clk);
        @(negedge clk);
        wr_reg(8'h0C, 32'h0000_0001);                   // lands on capture edge
        rd_chk(9, 8'h0C, 32'h0000_0001);
        wr_reg(8'h0C, 32'h0000_0001);
        rd_chk(4, 8'h0C, 32'h0);

        // R1: reset in mid-run clears state
        wr_reg(8'h80, 32'h0000_00FF);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_chk(1, 8'h00, 32'h0);
        rd_chk(1, 8'h04, 32'h0);
        rd_chk(1, 8'h80, 32'h0);
        rd_chk(1, 8'h10, 32'h0);
        chk(1, {31'h0, bank_irq}, 32'h0);
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule